// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Controller

This block sits between a simple word-wide register bus and an 8-bit NAND flash device. Each host write to the command, address or data register becomes exactly one timed write cycle on the flash bus. Each host read of the data register becomes exactly one timed read cycle. Every cycle goes through four phases: setup, strobe, hold and a ready delay. The length of each phase is programmed separately for reads and for writes in a single 32-bit timing word. The block also provides:

- a forced chip-enable control bit;
- a synchronized view of the ready/busy pin;
- a transfer counter that raises an event when it runs out;
- two maskable interrupt sources;
- a self-clearing software reset.

The cycle engine is a state machine with five states:

- `PH_IDLE`: leaves on an accepted cycle request (**start**) and goes to `PH_SETUP`.
- `PH_SETUP`: leaves on counter expiry (**setup_done**) and goes to `PH_STROBE`.
- `PH_STROBE`: leaves on counter expiry (**strobe_done**) and goes to `PH_HOLD`. A read byte is captured on this transition.
- `PH_HOLD`: leaves on counter expiry (**hold_done**) and goes to `PH_READY`.
- `PH_READY`: leaves on counter expiry while the synchronized ready line is high (**cycle_done**) and returns to `PH_IDLE`.

While the engine is not in `PH_IDLE`, every register access is stalled with `reg_wait`. The host keeps its request asserted until `reg_wait` is low at a rising edge; the access completes at that edge.

Top module: `nand_cycle_ctrl`

Register word indices on `reg_sel`:

| Index | Register |
|---|---|
| 0 | data |
| 1 | address |
| 2 | command |
| 3 | control |
| 4 | config |
| 5 | status |
| 6 | interrupt status |
| 7 | interrupt enable |
| 8 | interrupt clear |
| 9 | timing |
| 10 | transfer count |

## Requirements
- R1: The timing word holds eight 4-bit fields. Write-cycle fields: ready delay [31:28], strobe width [27:24], hold [23:20], setup [19:16]. Read-cycle fields: ready delay [15:12], strobe width [11:8], hold [7:4], setup [3:0]. Each phase lasts its field value in clock cycles, and a value of 0 lasts 1 cycle. A cycle keeps `nand_ce_n` low for setup+width+hold+ready cycles when ready is already high. The timing word reads back as written.
- R2: A write to the command register issues one write cycle. `nand_cle` is high during it, `nand_ale` is low, and the bus carries bits [7:0] of the written word.
- R3: A write to the address register issues one write cycle. `nand_ale` is high during it, `nand_cle` is low, and the bus carries bits [7:0].
- R4: A write to the data register issues one write cycle with `nand_cle` and `nand_ale` both low, carrying bits [7:0]. A read of the data register issues one read cycle: `nand_re_n` is low for the read strobe width and the data bus is not driven. The read returns, zero-extended, the byte present on `nand_dq_i` in the last strobe cycle. `nand_we_n` falls only in write cycles and `nand_re_n` only in read cycles.
- R5: After its ready delay, a cycle stays in `PH_READY` with `nand_ce_n` low for as long as the synchronized ready line is low. It completes once that line is high.
- R6: Any register access made while a cycle is in progress keeps `reg_wait` high until the cycle ends. A data read keeps `reg_wait` high until its own cycle has finished.
- R7: Config bit 5 set forces `nand_ce_n` low. With it clear, `nand_ce_n` is low only while a cycle is in progress. The bit reads back as written.
- R8: Status bit 0 equals the ready/busy pin (1 = ready) after SYNC_STAGES clock cycles of synchronization.
- R9: Interrupt status bit 0 is set by a rising edge of the synchronized ready line. Writing 1s to the interrupt clear register clears the matching status bits. `irq` is high exactly when some status bit and its interrupt enable bit are both set.
- R10: Writing 1 to control bit 2 resets all registers (timing, config, enables, status, transfer count) and the cycle state to idle. The control register always reads 0.
- R11: A nonzero transfer count decrements by one at the end of each data cycle (read or write). The decrement that reaches zero sets interrupt status bit 1. A zero count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register word index |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid when `reg_wait` is low |
| reg_wait | output | 1 | Stall: the request must be held |
| irq | output | 1 | Interrupt output |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |
| nand_dq_i | input | 8 | Flash data in |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Data output enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |

## Verification
The bench builds the block with SYNC_STAGES=2 and an 8-bit transfer counter. This keeps the delay from the ready pin to status and interrupt at two cycles, and lets a two-step countdown reach the transfer-count event quickly. It programs unequal read and write phase values and an all-zero timing word. Distinct strobe, chip-enable and stall lengths then separate the read field set from the write field set, each field from the others, and the zero-as-one rule.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    localparam int FIELD_W = 4;
    localparam int SEL_W   = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_READY
    } phase_e;

    typedef enum logic [1:0] {
        CY_CMD,
        CY_ADDR,
        CY_DATA_WR,
        CY_DATA_RD
    } cyc_kind_e;

    // one direction's phase lengths, ordered as in the timing word half
    typedef struct packed {
        logic [FIELD_W-1:0] rdy;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
    } phase_set_t;

    localparam logic [SEL_W-1:0] RI_DATA  = 4'd0;
    localparam logic [SEL_W-1:0] RI_ADDR  = 4'd1;
    localparam logic [SEL_W-1:0] RI_CMD   = 4'd2;
    localparam logic [SEL_W-1:0] RI_CTRL  = 4'd3;
    localparam logic [SEL_W-1:0] RI_CFG   = 4'd4;
    localparam logic [SEL_W-1:0] RI_STAT  = 4'd5;
    localparam logic [SEL_W-1:0] RI_ISTAT = 4'd6;
    localparam logic [SEL_W-1:0] RI_IEN   = 4'd7;
    localparam logic [SEL_W-1:0] RI_ICLR  = 4'd8;
    localparam logic [SEL_W-1:0] RI_TIME  = 4'd9;
    localparam logic [SEL_W-1:0] RI_XCNT  = 4'd10;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_sync,
    output logic rb_rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= rb_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rb_sync = chain_q[STAGES-1];
    assign rb_rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
    import nand_cyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       srst,
    input  logic       start,
    input  cyc_kind_e  kind,
    input  logic [7:0] wbyte,
    input  phase_set_t tim_wr,
    input  phase_set_t tim_rd,
    input  logic       rb_ok,
    input  logic [7:0] dq_i,
    output logic       busy,
    output logic       done,
    output cyc_kind_e  done_kind,
    output logic [7:0] rbyte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_o,
    output logic       dq_oe
);
    phase_e             state_q;
    logic [FIELD_W-1:0] cnt_q;
    cyc_kind_e          kind_q;
    logic [7:0]         byte_q;
    logic [7:0]         rbyte_q;
    phase_set_t         act_set;
    logic               is_rd;

    function automatic logic [FIELD_W-1:0] ld(input logic [FIELD_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    always_comb begin
        is_rd   = (state_q == PH_IDLE) ? (kind == CY_DATA_RD) : (kind_q == CY_DATA_RD);
        act_set = is_rd ? tim_rd : tim_wr;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            kind_q  <= CY_CMD;
            byte_q  <= '0;
            rbyte_q <= '0;
        end else if (srst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            kind_q  <= CY_CMD;
            byte_q  <= '0;
            rbyte_q <= '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (start) begin
                        state_q <= PH_SETUP;
                        cnt_q   <= ld(act_set.setup);
                        kind_q  <= kind;
                        byte_q  <= wbyte;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        state_q <= PH_STROBE;
                        cnt_q   <= ld(act_set.width);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        state_q <= PH_HOLD;
                        cnt_q   <= ld(act_set.hold);
                        if (kind_q == CY_DATA_RD) rbyte_q <= dq_i;
                    end else cnt_q <= cnt_q - 1'b1;
                end
                PH_HOLD: begin
                    if (cnt_q == '0) begin
                        state_q <= PH_READY;
                        cnt_q   <= ld(act_set.rdy);
                    end else cnt_q <= cnt_q - 1'b1;
                end
                PH_READY: begin
                    if (cnt_q != '0)  cnt_q   <= cnt_q - 1'b1;
                    else if (rb_ok)   state_q <= PH_IDLE;
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cle   = 1'b0;
        ale   = 1'b0;
        we_n  = 1'b1;
        re_n  = 1'b1;
        dq_oe = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            PH_IDLE: busy = 1'b0;
            PH_SETUP, PH_STROBE, PH_HOLD: begin
                cle   = (kind_q == CY_CMD);
                ale   = (kind_q == CY_ADDR);
                dq_oe = (kind_q != CY_DATA_RD);
                if (state_q == PH_STROBE) begin
                    we_n = (kind_q == CY_DATA_RD);
                    re_n = (kind_q != CY_DATA_RD);
                end
            end
            PH_READY: done = (cnt_q == '0) && rb_ok;
            default: busy = 1'b0;
        endcase
    end

    assign dq_o      = byte_q;
    assign rbyte     = rbyte_q;
    assign done_kind = kind_q;

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R2
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R4
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

endmodule

// File: rtl/nand_regs.sv
module nand_regs
    import nand_cyc_pkg::*;
#(
    parameter int XCNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_wait,
    output logic             irq,
    input  logic             fsm_busy,
    input  logic             fsm_done,
    input  cyc_kind_e        fsm_done_kind,
    input  logic [7:0]       fsm_rbyte,
    input  logic             rb_sync,
    input  logic             rb_rise,
    output logic             srst,
    output logic             start,
    output cyc_kind_e        kind,
    output logic [7:0]       wbyte,
    output phase_set_t       tim_wr,
    output phase_set_t       tim_rd,
    output logic             ce_force
);
    localparam int HALF_W = 4 * FIELD_W;

    logic [2*HALF_W-1:0] timing_q;
    logic                ce_q;
    logic [1:0]          ien_q;
    logic [1:0]          ist_q;
    logic [XCNT_W-1:0]   xcnt_q;
    logic                rd_done_q;
    logic                rd_req, cyc_wr_req, accept, data_end;
    logic [1:0]          ist_set, ist_clr;

    always_comb begin
        rd_req     = reg_rd && !reg_wr && (reg_sel == RI_DATA);
        cyc_wr_req = reg_wr && (reg_sel == RI_DATA || reg_sel == RI_ADDR || reg_sel == RI_CMD);
        reg_wait   = fsm_busy || (rd_req && !rd_done_q);
        accept     = (reg_wr || reg_rd) && !reg_wait;
        start      = !fsm_busy && (cyc_wr_req || (rd_req && !rd_done_q));
        srst       = accept && reg_wr && (reg_sel == RI_CTRL) && reg_wdata[2];
        unique case (1'b1)
            rd_req:              kind = CY_DATA_RD;
            reg_sel == RI_CMD:   kind = CY_CMD;
            reg_sel == RI_ADDR:  kind = CY_ADDR;
            default:             kind = CY_DATA_WR;
        endcase
        data_end = fsm_done && (fsm_done_kind == CY_DATA_WR || fsm_done_kind == CY_DATA_RD);
        ist_set  = {data_end && (xcnt_q == XCNT_W'(1)), rb_rise};
        ist_clr  = (accept && reg_wr && reg_sel == RI_ICLR) ? reg_wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing_q  <= '0;
            ce_q      <= 1'b0;
            ien_q     <= '0;
            ist_q     <= '0;
            xcnt_q    <= '0;
            rd_done_q <= 1'b0;
        end else if (srst) begin
            timing_q  <= '0;
            ce_q      <= 1'b0;
            ien_q     <= '0;
            ist_q     <= '0;
            xcnt_q    <= '0;
            rd_done_q <= 1'b0;
        end else begin
            ist_q <= (ist_q & ~ist_clr) | ist_set;
            if (fsm_done && fsm_done_kind == CY_DATA_RD) rd_done_q <= 1'b1;
            else if (accept && rd_req)                  rd_done_q <= 1'b0;
            if (accept && reg_wr && reg_sel == RI_XCNT) xcnt_q <= reg_wdata[XCNT_W-1:0];
            else if (data_end && xcnt_q != '0)          xcnt_q <= xcnt_q - 1'b1;
            if (accept && reg_wr) begin
                unique case (reg_sel)
                    RI_TIME: timing_q <= reg_wdata;
                    RI_CFG:  ce_q     <= reg_wdata[5];
                    RI_IEN:  ien_q    <= reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            RI_DATA:  reg_rdata = {24'd0, fsm_rbyte};
            RI_CFG:   reg_rdata = {26'd0, ce_q, 5'd0};
            RI_STAT:  reg_rdata = {31'd0, rb_sync};
            RI_ISTAT: reg_rdata = {30'd0, ist_q};
            RI_IEN:   reg_rdata = {30'd0, ien_q};
            RI_TIME:  reg_rdata = timing_q;
            RI_XCNT:  reg_rdata = 32'(xcnt_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign tim_wr   = timing_q[2*HALF_W-1:HALF_W];
    assign tim_rd   = timing_q[HALF_W-1:0];
    assign wbyte    = reg_wdata[7:0];
    assign ce_force = ce_q;
    assign irq      = |(ist_q & ien_q);

    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (timing_q == '0 && !ce_q && ien_q == '0));
    // R9
    rdy_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_rise && !srst) |=> ist_q[0]);

endmodule

// File: rtl/nand_cycle_ctrl.sv
module nand_cycle_ctrl
    import nand_cyc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int XCNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_wait,
    output logic        irq,
    input  logic        nand_rb,
    input  logic [7:0]  nand_dq_i,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic        nand_ce_n
);
    logic       rb_s, rb_rise, busy, done, srst, start, ce_force;
    cyc_kind_e  kind, done_kind;
    logic [7:0] wbyte, rbyte;
    phase_set_t tim_wr, tim_rd;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rb_async(nand_rb),
        .rb_sync(rb_s), .rb_rise(rb_rise)
    );

    nand_regs #(.XCNT_W(XCNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_wait(reg_wait), .irq(irq), .fsm_busy(busy), .fsm_done(done),
        .fsm_done_kind(done_kind), .fsm_rbyte(rbyte), .rb_sync(rb_s),
        .rb_rise(rb_rise), .srst(srst), .start(start), .kind(kind),
        .wbyte(wbyte), .tim_wr(tim_wr), .tim_rd(tim_rd), .ce_force(ce_force)
    );

    nand_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .srst(srst), .start(start), .kind(kind),
        .wbyte(wbyte), .tim_wr(tim_wr), .tim_rd(tim_rd), .rb_ok(rb_s),
        .dq_i(nand_dq_i), .busy(busy), .done(done), .done_kind(done_kind),
        .rbyte(rbyte), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
        .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    assign nand_ce_n = ~(ce_force | busy);

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && busy) |-> reg_wait);
    // R7
    ce_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

endmodule

// File: tb/test_nand_cycle_ctrl.sv
module test_nand_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_wait, irq;
    logic        nand_rb = 1'b1;
    logic [7:0]  nand_dq_i = '0;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n;

    int checks = 0, fails = 0;
    bit finished = 0;
    int we_lo, re_lo, ce_lo, cle_we, ale_we, oe_we;
    logic [7:0] wdq;

    localparam logic [3:0] S_DATA = 0, S_ADDR = 1, S_CMD = 2, S_CTRL = 3, S_CFG = 4,
        S_STAT = 5, S_ISTAT = 6, S_IEN = 7, S_ICLR = 8, S_TIME = 9, S_XCNT = 10;

    nand_cycle_ctrl #(.SYNC_STAGES(2), .XCNT_W(8)) i_nand_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait), .irq(irq),
        .nand_rb(nand_rb), .nand_dq_i(nand_dq_i), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (!nand_we_n) begin
            we_lo++; wdq = nand_dq_o;
            if (nand_cle) cle_we++;
            if (nand_ale) ale_we++;
            if (nand_dq_oe) oe_we++;
        end
        if (!nand_re_n) re_lo++;
        if (!nand_ce_n) ce_lo++;
    end

    task automatic clr_mon();
        we_lo = 0; re_lo = 0; ce_lo = 0; cle_we = 0; ale_we = 0; oe_we = 0; wdq = 8'h00;
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] sel, input logic [31:0] d, output int stall);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1; stall = 0;
        #1;
        while (reg_wait) begin stall++; @(negedge clk); #1; end
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] sel, output logic [31:0] d, output int stall);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1; stall = 0;
        #1;
        while (reg_wait) begin stall++; @(negedge clk); #1; end
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d; int st;
        @(negedge clk);
        check("R7", "ce_n after reset", nand_ce_n, 1);
        check("R4", "we_n/re_n after reset", {nand_we_n, nand_re_n}, 2'b11);
        check("R9", "irq after reset", irq, 0);
        bus_rd(S_TIME, d, st); check("R1", "timing reset", d, 0);
        bus_rd(S_STAT, d, st); check("R8", "status ready", d, 1);
    endtask

    task automatic t_timing();
        logic [31:0] d; int st;
        bus_wr(S_TIME, 32'h0312_3420, st);
        bus_rd(S_TIME, d, st); check("R1", "timing readback", d, 32'h0312_3420);
    endtask

    task automatic t_cmd();
        int st;
        clr_mon(); bus_wr(S_CMD, 32'h1234_5690, st); idle(12);
        check("R1", "write width", we_lo, 3);
        check("R1", "write cycle ce length", ce_lo, 7);
        check("R2", "cle during strobe", cle_we, 3);
        check("R2", "ale during cmd", ale_we, 0);
        check("R2", "cmd byte", wdq, 8'h90);
        check("R2", "bus driven", oe_we, 3);
    endtask

    task automatic t_addr();
        int st;
        clr_mon(); bus_wr(S_ADDR, 32'h0000_FFC3, st); idle(12);
        check("R3", "ale during strobe", ale_we, 3);
        check("R3", "cle during addr", cle_we, 0);
        check("R3", "addr byte", wdq, 8'hC3);
    endtask

    task automatic t_data_wr();
        int st;
        clr_mon(); bus_wr(S_DATA, 32'hAB00_005A, st); idle(12);
        check("R4", "data latch lines", {cle_we, ale_we}, 0);
        check("R4", "data byte", wdq, 8'h5A);
        check("R4", "data strobe", we_lo, 3);
    endtask

    task automatic t_data_rd();
        logic [31:0] d; int st;
        nand_dq_i = 8'hA5;
        clr_mon(); bus_rd(S_DATA, d, st); idle(2);
        check("R4", "read data", d, 32'h0000_00A5);
        check("R4", "read strobe width", re_lo, 4);
        check("R4", "no write strobe in read", we_lo, 0);
        check("R1", "read cycle ce length", ce_lo, 10);
        check("R6", "data read stall", st, 11);
        nand_dq_i = 8'h00;
    endtask

    task automatic t_stall();
        logic [31:0] d; int st;
        bus_wr(S_CMD, 32'h70, st);
        bus_rd(S_STAT, d, st);
        check("R6", "stall during cycle", st, 7);
        check("R8", "status after stall", d, 1);
    endtask

    task automatic t_ready_wait();
        int st;
        nand_rb = 1'b0; idle(4);
        clr_mon(); bus_wr(S_CMD, 32'hFF, st); idle(30);
        check("R5", "ce held while busy", nand_ce_n, 0);
        check("R5", "strobe done before wait", we_lo, 3);
        nand_rb = 1'b1; idle(8);
        check("R5", "cycle ends when ready", nand_ce_n, 1);
    endtask

    task automatic t_irq();
        logic [31:0] d; int st;
        bus_rd(S_ISTAT, d, st); check("R9", "ready event", d, 1);
        check("R9", "irq masked", irq, 0);
        bus_wr(S_IEN, 1, st); check("R9", "irq enabled", irq, 1);
        bus_wr(S_ICLR, 1, st);
        bus_rd(S_ISTAT, d, st); check("R9", "cleared", d, 0);
        check("R9", "irq after clear", irq, 0);
    endtask

    task automatic t_xcount();
        logic [31:0] d; int st;
        bus_wr(S_XCNT, 2, st); bus_wr(S_IEN, 2, st);
        bus_wr(S_DATA, 8'h11, st);
        bus_rd(S_ISTAT, d, st); check("R11", "no event at 1", d, 0);
        bus_rd(S_XCNT, d, st); check("R11", "count 1", d, 1);
        bus_wr(S_DATA, 8'h22, st);
        bus_rd(S_ISTAT, d, st); check("R11", "event at 0", d, 2);
        check("R9", "irq from count", irq, 1);
        bus_wr(S_ADDR, 8'h33, st);
        bus_rd(S_XCNT, d, st); check("R11", "count stays 0", d, 0);
        bus_wr(S_ICLR, 3, st); check("R9", "irq cleared", irq, 0);
    endtask

    task automatic t_ce_force();
        logic [31:0] d; int st;
        bus_wr(S_CFG, 32'h20, st); idle(1);
        check("R7", "forced low", nand_ce_n, 0);
        bus_rd(S_CFG, d, st); check("R7", "cfg readback", d, 32'h20);
        bus_wr(S_CFG, 0, st); idle(1);
        check("R7", "released", nand_ce_n, 1);
    endtask

    task automatic t_zero_fields();
        int st;
        bus_wr(S_TIME, 0, st);
        clr_mon(); bus_wr(S_CMD, 8'h01, st); idle(8);
        check("R1", "zero width as one", we_lo, 1);
        check("R1", "zero phases ce length", ce_lo, 4);
    endtask

    task automatic t_srst();
        logic [31:0] d; int st;
        bus_wr(S_TIME, 32'h5555_5555, st); bus_wr(S_CFG, 32'h20, st); bus_wr(S_IEN, 3, st);
        bus_wr(S_CTRL, 4, st); idle(1);
        bus_rd(S_CTRL, d, st); check("R10", "ctrl reads 0", d, 0);
        bus_rd(S_TIME, d, st); check("R10", "timing cleared", d, 0);
        bus_rd(S_CFG, d, st);  check("R10", "cfg cleared", d, 0);
        bus_rd(S_IEN, d, st);  check("R10", "enables cleared", d, 0);
        check("R10", "ce released", nand_ce_n, 1);
    endtask

    initial begin
        clr_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_cmd();
        t_addr();
        t_data_wr();
        t_data_rd();
        t_stall();
        t_ready_wait();
        t_irq();
        t_xcount();
        t_ce_force();
        t_zero_fields();
        t_srst();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule